// File: doc/BRIEF.md
# DMA Global Control and Status Register

This block is the single global register of a multi-channel DMA controller. It holds one master enable bit and two sticky error flags. One flag records an address error and the other records a non-maskable interrupt. From these bits, together with each channel's own enable and transfer-end bits, it produces one transfer-permit signal per channel. The transfer engine uses these signals to decide whether a channel may move data.

Software reaches the register through a plain read/write port. Only the two hardware event inputs can raise the flags. To clear a flag, software must first read it as 1 and then write 0 to it. A flag that was never observed therefore cannot be wiped out by accident. Any raised flag, or a cleared master enable, removes the permit from every channel at once.

Top module: `dma_gcsr`

## Requirements
- R1: After power-on reset all three register bits read 0 and every permit output is 0. The bit positions are: master enable at bit 0, NMI flag at bit 1, address-error flag at bit 2.
- R2: A channel's permit is 1 only when all of these hold: the master enable is 1, the channel enable is 1, the channel's transfer-end bit is 0, and both flags are 0. The permit follows these inputs in the same cycle.
- R3: An address-error event sets bit 2 at the next clock edge. While bit 2 is 1, all permits are 0.
- R4: An NMI event sets bit 1 at the next clock edge, whatever the master enable holds. While bit 1 is 1, all permits are 0.
- R5: A CPU write of 1 to bit 1 or bit 2 never sets that flag.
- R6: A flag is cleared by a write of 0 only if the latest read of the register showed that flag as 1 and no write has come in between. A write of 0 to a flag that was not read this way leaves it set.
- R7: A new event on a flag cancels any earlier read of that flag. A following write of 0 then leaves the flag set.
- R8: When an event and a qualifying clearing write reach the same flag in the same cycle, the flag stays set.
- R9: The synchronous manual reset input clears all three bits and all read history at the next edge. It takes priority over events and writes.
- R10: A write sets the master enable to written bit 0 at the next edge. Clearing it drops every permit, even while channels are enabled and have not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous manual reset, active high |
| rd_en | input | 1 | CPU read strobe for the register |
| wr_en | input | 1 | CPU write strobe for the register |
| wr_data | input | 3 | CPU write data |
| rd_data | output | 3 | Current register value {address error, NMI, master enable} |
| addr_err_evt | input | 1 | Address-error event pulse |
| nmi_evt | input | 1 | NMI event pulse |
| chan_en | input | NCH | Per-channel enable bits |
| chan_done | input | NCH | Per-channel transfer-end bits |
| xfer_ok | output | NCH | Per-channel transfer permit |

## Verification
The assertions check several properties on every cycle. Permits stay low whenever the master enable is clear or either flag is set, and they never rise for a channel that is disabled or finished. Events always set their flag, software never sets one, a flag only falls after a reset or an armed clearing write, and a write lands in the master enable. The read-then-write ordering, the loss of read history when a new event arrives, and the same-cycle collision of a set and a clear are sequences spread over several cycles. Only the bench's directed scenarios and its reference model walk through them.

// File: rtl/dma_gcsr.sv
module dma_gcsr #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           rd_en,
  input  logic           wr_en,
  input  logic [2:0]     wr_data,
  output logic [2:0]     rd_data,
  input  logic           addr_err_evt,
  input  logic           nmi_evt,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] chan_done,
  output logic [NCH-1:0] xfer_ok
);
  localparam int NFLAG = 2;

  logic             dme;
  logic [NFLAG-1:0] flag;
  logic [NFLAG-1:0] armed;
  logic [NFLAG-1:0] evt;

  assign evt = {addr_err_evt, nmi_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dme <= 1'b0;
    else if (soft_rst) dme <= 1'b0;
    else if (wr_en)    dme <= wr_data[0];
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[i]  <= 1'b0;
        armed[i] <= 1'b0;
      end else if (soft_rst) begin
        flag[i]  <= 1'b0;
        armed[i] <= 1'b0;
      end else if (evt[i]) begin
        flag[i]  <= 1'b1;
        armed[i] <= 1'b0;
      end else if (wr_en) begin
        armed[i] <= 1'b0;
        if (armed[i] && !wr_data[i+1]) flag[i] <= 1'b0;
      end else if (rd_en && flag[i]) begin
        armed[i] <= 1'b1;
      end
    end
  end

  assign rd_data = {flag, dme};
  assign xfer_ok = (dme && flag == '0) ? (chan_en & ~chan_done) : '0;
endmodule

module dma_gcsr_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           soft_rst,
  input logic           rd_en,
  input logic           wr_en,
  input logic [2:0]     wr_data,
  input logic [2:0]     rd_data,
  input logic           addr_err_evt,
  input logic           nmi_evt,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] chan_done,
  input logic [NCH-1:0] xfer_ok,
  input logic [1:0]     armed
);
  a_r2_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[0] || rd_data[1] || rd_data[2]) |-> xfer_ok == '0);
  a_r2_chan_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok & (~chan_en | chan_done)) == '0);
  a_r3_ae_set: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err_evt && !soft_rst) |=> rd_data[2]);
  a_r4_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_evt && !soft_rst) |=> rd_data[1]);
  a_r5_no_cpu_set_ae: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[2] && !addr_err_evt) |=> !rd_data[2]);
  a_r5_no_cpu_set_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[1] && !nmi_evt) |=> !rd_data[1]);
  a_r6_ae_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[2]) |-> ($past(soft_rst) ||
      ($past(wr_en) && $past(armed[1]) && !$past(wr_data[2]))));
  a_r6_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[1]) |-> ($past(soft_rst) ||
      ($past(wr_en) && $past(armed[0]) && !$past(wr_data[1]))));
  a_r9_manual_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> rd_data == 3'b000);
  a_r10_dme_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst) |=> rd_data[0] == $past(wr_data[0]));
endmodule

bind dma_gcsr dma_gcsr_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_gcsr_test.sv
module dma_gcsr_test;
  localparam int PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0, addr_err_evt = 1'b0, nmi_evt = 1'b0;
  logic [2:0] wr_data = '0;
  logic [2:0] rd_data;
  logic [NCH-1:0] chan_en = '0, chan_done = '0, xfer_ok;
  int total = 0, bad = 0;

  logic m_dme, m_ae, m_nmi, m_aa, m_an;

  always #(PERIOD/2) clk = ~clk;

  dma_gcsr #(.NCH(NCH)) uut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_dme, m_ae, m_nmi, m_aa, m_an} <= '0;
    end else if (soft_rst) begin
      {m_dme, m_ae, m_nmi, m_aa, m_an} <= '0;
    end else begin
      if (wr_en) m_dme <= wr_data[0];
      if (addr_err_evt) begin m_ae <= 1'b1; m_aa <= 1'b0; end
      else if (wr_en) begin m_aa <= 1'b0; if (m_aa && !wr_data[2]) m_ae <= 1'b0; end
      else if (rd_en && m_ae) m_aa <= 1'b1;
      if (nmi_evt) begin m_nmi <= 1'b1; m_an <= 1'b0; end
      else if (wr_en) begin m_an <= 1'b0; if (m_an && !wr_data[1]) m_nmi <= 1'b0; end
      else if (rd_en && m_nmi) m_an <= 1'b1;
    end
  end

  function automatic logic [NCH-1:0] exp_ok(logic d, logic a, logic n,
                                            logic [NCH-1:0] e, logic [NCH-1:0] t);
    return (d && !a && !n) ? (e & ~t) : '0;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step(logic rd, logic wr, logic [2:0] wd, logic ae, logic nm,
                      logic sr, logic [NCH-1:0] de, logic [NCH-1:0] te);
    @(negedge clk);
    rd_en = rd; wr_en = wr; wr_data = wd; addr_err_evt = ae; nmi_evt = nm;
    soft_rst = sr; chan_en = de; chan_done = te;
    #1;
    chk("R6 model regs", {5'd0, rd_data}, {5'd0, m_ae, m_nmi, m_dme});
    chk("R2 model permit", {4'd0, xfer_ok}, {4'd0, exp_ok(m_dme, m_ae, m_nmi, de, te)});
  endtask

  task automatic idle(logic [NCH-1:0] de, logic [NCH-1:0] te);
    step(0, 0, 3'b000, 0, 0, 0, de, te);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    #(PERIOD * 3);
    #1;
    chk("R1 reset regs", {5'd0, rd_data}, 8'h00);
    chk("R1 reset permit", {4'd0, xfer_ok}, 8'h00);
    rst_n = 1'b1;
    // R5 / R10: write all ones, only master enable takes
    step(0, 1, 3'b111, 0, 0, 0, 4'hF, 4'h0);
    idle(4'hF, 4'h0);
    chk("R5 write 1 no set", {5'd0, rd_data}, 8'h01);
    chk("R2 all permitted", {4'd0, xfer_ok}, 8'h0F);
    idle(4'hF, 4'h5);
    chk("R2 done masks", {4'd0, xfer_ok}, 8'h0A);
    idle(4'h3, 4'h0);
    chk("R2 enable masks", {4'd0, xfer_ok}, 8'h03);
    // R3: address error
    step(0, 0, 3'b000, 1, 0, 0, 4'hF, 4'h0);
    idle(4'hF, 4'h0);
    chk("R3 ae set", {5'd0, rd_data}, 8'h05);
    chk("R3 ae blocks", {4'd0, xfer_ok}, 8'h00);
    // R6: unarmed write of 0 keeps flag
    step(0, 1, 3'b001, 0, 0, 0, 4'hF, 4'h0);
    idle(4'hF, 4'h0);
    chk("R6 unarmed keep", {5'd0, rd_data}, 8'h05);
    step(1, 0, 3'b000, 0, 0, 0, 4'hF, 4'h0);
    step(0, 1, 3'b001, 0, 0, 0, 4'hF, 4'h0);
    idle(4'hF, 4'h0);
    chk("R6 armed clear", {5'd0, rd_data}, 8'h01);
    chk("R6 permit back", {4'd0, xfer_ok}, 8'h0F);
    // R4: NMI with master enable cleared
    step(0, 1, 3'b000, 0, 0, 0, 4'hF, 4'h0);
    step(0, 0, 3'b000, 0, 1, 0, 4'hF, 4'h0);
    idle(4'hF, 4'h0);
    chk("R4 nmi set halted", {5'd0, rd_data}, 8'h02);
    // R7: read, new event, write 0 -> stays
    step(1, 0, 3'b000, 0, 0, 0, 4'hF, 4'h0);
    step(0, 0, 3'b000, 0, 1, 0, 4'hF, 4'h0);
    step(0, 1, 3'b001, 0, 0, 0, 4'hF, 4'h0);
    idle(4'hF, 4'h0);
    chk("R7 rearm needed", {5'd0, rd_data}, 8'h03);
    chk("R4 nmi blocks", {4'd0, xfer_ok}, 8'h00);
    // R8: read, then write 0 with event same cycle
    step(1, 0, 3'b000, 0, 0, 0, 4'hF, 4'h0);
    step(0, 1, 3'b001, 0, 1, 0, 4'hF, 4'h0);
    idle(4'hF, 4'h0);
    chk("R8 set wins", {5'd0, rd_data}, 8'h03);
    // R9: manual reset beats an event
    step(0, 0, 3'b000, 1, 0, 1, 4'hF, 4'h0);
    idle(4'hF, 4'h0);
    chk("R9 manual reset", {5'd0, rd_data}, 8'h00);
    // R10: clearing master enable drops permits
    step(0, 1, 3'b001, 0, 0, 0, 4'hF, 4'h0);
    idle(4'hF, 4'h0);
    chk("R10 enabled", {4'd0, xfer_ok}, 8'h0F);
    step(0, 1, 3'b000, 0, 0, 0, 4'hF, 4'h0);
    chk("R10 not before edge", {4'd0, xfer_ok}, 8'h0F);
    idle(4'hF, 4'h0);
    chk("R10 dropped", {4'd0, xfer_ok}, 8'h00);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 3) == 0, ($urandom % 4) == 0, 3'($urandom),
           ($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 60) == 0,
           NCH'($urandom), NCH'($urandom));
    end
    idle('0, '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule